// File: doc/BRIEF.md
# SPI Burst Master Engine

This block is the shifting core of a master-only SPI controller. Software programs a control word (enable, soft reset, master select, clock polarity and phase, bit order, chip-select index and ownership) together with a byte count, then pulses a self-clearing start bit. The engine pulls each byte from an external transmit FIFO, shifts it out on MOSI while collecting MISO into a byte that is pushed to an external receive FIFO, and raises a one-cycle completion pulse when the counted burst is over. The SCLK half-period is a fixed number of system clocks set by a parameter.

Chip select can be driven by the engine (asserted for the whole burst) or owned by software, in which case the selected line follows a level bit, so it can stay asserted across several bursts. When the transmit FIFO runs dry in the middle of a burst, the engine parks SCLK at its idle level with chip select held and continues once a byte arrives.

Top module: `spi_burst_master`

## Requirements
- R1: Chip-select lines are active low. With hardware ownership, line `cs_sel` (0..3) is low exactly while `busy` is high and every other line is high; all lines are high while `enable` is 0 and at most one line is ever low.
- R2: With `cs_sw_own` = 1 and `enable` = 1, line `cs_sel` equals `cs_sw_level` regardless of burst state, and the other lines are high.
- R3: SCLK rests at `cpol` outside a byte; each byte gives 16 SCLK edges, one every `HALF_CYC` system clocks, the first `HALF_CYC` clocks after the byte is loaded.
- R4: With `cpha` = 0 MISO is sampled on the even-numbered edges (first, third, ...) and MOSI changes on odd ones; with `cpha` = 1 sampling is on odd-numbered edges and MOSI changes on even ones after the first.
- R5: `lsb_first` = 1 sends and assembles bit 0 first; `lsb_first` = 0 sends and assembles bit 7 first. MOSI is 0 outside a byte.
- R6: A `start` pulse in an idle cycle is accepted only when `enable` = 1, `soft_reset` = 0 and `master` = 1; `busy` then rises on the next clock and clears itself when the burst ends.
- R7: `done` is high for the one cycle after the last edge of the final byte, in which `busy` is already low; a start with `burst_len` = 0 gives `done` on the next clock with no SCLK activity.
- R8: When the transmit FIFO is empty between bytes of a burst, SCLK stays at `cpol`, chip select stays asserted, no pop occurs, and the burst resumes when data arrives.
- R9: `rx_push` is high for one cycle on the sampling edge of the eighth bit of each byte, with `rx_data` holding the complete byte including that bit.
- R10: `soft_reset` = 1 or `enable` = 0 returns the engine to idle on the next clock without a `done` pulse.
- R11: A start presented in the cycle `done` is high is accepted, so bursts can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global enable |
| master | input | 1 | Master select; starts accepted only when 1 |
| soft_reset | input | 1 | Forces the engine idle |
| cpol | input | 1 | SCLK idle level |
| cpha | input | 1 | Sampling phase select |
| lsb_first | input | 1 | Bit order select |
| cs_sel | input | 2 | Chip-select index |
| cs_sw_own | input | 1 | Software owns chip select |
| cs_sw_level | input | 1 | Software chip-select line level |
| start | input | 1 | Start pulse (write of 1 to the start bit) |
| burst_len | input | LEN_W | Bytes in the burst |
| busy | output | 1 | Start bit readback, high during a burst |
| done | output | 1 | Transfer-complete pulse |
| tx_data | input | 8 | Head of transmit FIFO |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_pop | output | 1 | Pop transmit FIFO |
| rx_data | output | 8 | Received byte |
| rx_push | output | 1 | Push receive FIFO |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Chip-select lines, active low |

## Verification
The sharpest coincidence is the completion pulse of one burst falling in the same cycle as the start of the next: the bench waits for `done`, drives `start` inside that very cycle under software-held chip select, and expects `busy` back on the following clock with the select line never released. A second overlap, the last-bit receive push landing on the same edge that ends the byte (phase 1), is judged by the per-cycle reference model, which predicts `rx_push`, `rx_data`, the state change and `done` for every clock across all four modes and both bit orders, with MISO changing every cycle.

// File: rtl/spi_burst_master.sv
module spi_burst_master #(
  parameter int HALF_CYC = 2,
  parameter int LEN_W    = 8,
  parameter int NCS      = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable,
  input  logic                   master,
  input  logic                   soft_reset,
  input  logic                   cpol,
  input  logic                   cpha,
  input  logic                   lsb_first,
  input  logic [$clog2(NCS)-1:0] cs_sel,
  input  logic                   cs_sw_own,
  input  logic                   cs_sw_level,
  input  logic                   start,
  input  logic [LEN_W-1:0]       burst_len,
  output logic                   busy,
  output logic                   done,
  input  logic [7:0]             tx_data,
  input  logic                   tx_empty,
  output logic                   tx_pop,
  output logic [7:0]             rx_data,
  output logic                   rx_push,
  output logic                   sclk,
  output logic                   mosi,
  input  logic                   miso,
  output logic [NCS-1:0]         cs_n
);

  localparam int DIV_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_CYC - 1);

  typedef enum logic [1:0] {IDLE, FETCH, SHIFT} st_t;

  st_t              st;
  logic [DIV_W-1:0] div;
  logic [3:0]       ph;
  logic [LEN_W-1:0] rem;
  logic [7:0]       txs, rxs, rx_next;
  logic             sclk_r;

  wire run      = enable & ~soft_reset;
  wire accept   = run & master & start & (st == IDLE);
  wire edge_now = run & (st == SHIFT) & (div == DIV_LAST);
  wire smp      = edge_now & (ph[0] == cpha);
  wire shf      = edge_now & (cpha ? (~ph[0] & (ph != 4'd0)) : (ph[0] & (ph != 4'd15)));

  assign rx_next = lsb_first ? {miso, rxs[7:1]} : {rxs[6:0], miso};
  assign rx_data = rx_next;
  assign rx_push = smp & (ph == (cpha ? 4'd15 : 4'd14));
  assign tx_pop  = run & (st == FETCH) & ~tx_empty;
  assign mosi    = (st == SHIFT) & (lsb_first ? txs[0] : txs[7]);
  assign sclk    = cpol ^ sclk_r;
  assign busy    = (st != IDLE);

  always_comb begin
    cs_n = '1;
    if (enable) begin
      if (cs_sw_own)  cs_n[cs_sel] = cs_sw_level;
      else if (busy)  cs_n[cs_sel] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; div <= '0; ph <= '0; rem <= '0;
      txs <= '0; rxs <= '0; sclk_r <= 1'b0; done <= 1'b0;
    end else if (!run) begin
      st <= IDLE; div <= '0; ph <= '0; sclk_r <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (accept) begin
          if (burst_len == '0) done <= 1'b1;
          else begin
            rem <= burst_len;
            st  <= FETCH;
          end
        end
        FETCH: if (!tx_empty) begin
          txs <= tx_data;
          st  <= SHIFT;
          div <= '0;
          ph  <= '0;
        end
        SHIFT: if (edge_now) begin
          div    <= '0;
          sclk_r <= ~sclk_r;
          if (smp) rxs <= rx_next;
          if (shf) txs <= lsb_first ? {1'b0, txs[7:1]} : {txs[6:0], 1'b0};
          if (ph == 4'd15) begin
            ph  <= '0;
            rem <= rem - 1'b1;
            if (rem == LEN_W'(1)) begin
              st   <= IDLE;
              done <= 1'b1;
            end else st <= FETCH;
          end else ph <= ph + 1'b1;
        end else div <= div + 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  assert_one_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);
  assert_sclk_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st != SHIFT) |-> (sclk == cpol));
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_no_pop_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);
  assert_push_in_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> (st == SHIFT));
  assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_reset || !enable) |=> (!busy && !done));

endmodule

// File: tb/sim_spi_burst_master.sv
module sim_spi_burst_master;
  localparam int PERIOD = 10;
  localparam int HALF   = 2;

  logic clk = 0, rst_n = 0;
  logic enable = 0, master = 0, soft_reset = 0, cpol = 0, cpha = 0, lsb_first = 0;
  logic [1:0] cs_sel = 0;
  logic cs_sw_own = 0, cs_sw_level = 1, start = 0, miso = 0;
  logic [7:0] burst_len = 0;
  logic busy, done, tx_pop, rx_push, sclk, mosi;
  logic [7:0] rx_data;
  logic [3:0] cs_n;

  logic [7:0] mem [0:255];
  logic [7:0] rd = 0, wr = 0;
  wire  [7:0] tx_data  = mem[rd];
  wire        tx_empty = (rd == wr);

  int tests = 0, fails = 0, done_seen = 0, push_seen = 0, pop_seen = 0;
  bit finished = 0, checking = 0;

  always #(PERIOD/2) clk = ~clk;

  spi_burst_master #(.HALF_CYC(HALF), .LEN_W(8), .NCS(4)) u0 (
    .clk, .rst_n, .enable, .master, .soft_reset, .cpol, .cpha, .lsb_first,
    .cs_sel, .cs_sw_own, .cs_sw_level, .start, .burst_len, .busy, .done,
    .tx_data, .tx_empty, .tx_pop, .rx_data, .rx_push, .sclk, .mosi, .miso, .cs_n);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: state as plain integers
  int m_st = 0, m_div = 0, m_ph = 0, m_rem = 0, m_nrx = 0;
  bit m_done = 0;
  logic [7:0] m_byte = 0, m_bits = 0;
  int lfsr = 32'h1ace;

  always @(posedge clk) begin
    #1;
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
    miso = lfsr[0];
  end

  always @(posedge clk) begin
    bit nd;
    nd = 0;
    if (!rst_n) begin
      m_st = 0; m_div = 0; m_ph = 0;
    end else if (!enable || soft_reset) begin
      m_st = 0; m_div = 0; m_ph = 0;
    end else begin
      case (m_st)
        0: if (start && master) begin
             if (burst_len == 0) nd = 1;
             else begin m_st = 1; m_rem = burst_len; end
           end
        1: if (rd != wr) begin
             m_byte = mem[rd]; rd <= rd + 1;
             m_st = 2; m_div = 0; m_ph = 0; m_nrx = 0;
           end
        default: if (m_div == HALF - 1) begin
             m_div = 0;
             if ((m_ph % 2) == cpha) begin m_bits[m_nrx] = miso; m_nrx++; end
             if (m_ph == 15) begin
               m_ph = 0; m_rem--;
               if (m_rem == 0) begin m_st = 0; nd = 1; end else m_st = 1;
             end else m_ph++;
           end else m_div++;
      endcase
    end
    m_done = nd;
  end

  always @(negedge clk) begin
    if (rst_n && checking && !finished) begin
      int k;
      bit edge_now, e_push, e_mosi, e_pop;
      logic [7:0] e_rx;
      logic [3:0] e_cs;
      edge_now = (m_st == 2) && (m_div == HALF - 1) && enable && !soft_reset;
      e_push = edge_now && ((m_ph % 2) == cpha) && (m_nrx == 7);
      e_pop  = (m_st == 1) && enable && !soft_reset && (rd != wr);
      for (int j = 0; j < 7; j++) e_rx[lsb_first ? j : 7 - j] = m_bits[j];
      e_rx[lsb_first ? 7 : 0] = miso;
      k = cpha ? ((m_ph > 0) ? (m_ph - 1) / 2 : 0) : m_ph / 2;
      e_mosi = (m_st == 2) ? (lsb_first ? m_byte[k] : m_byte[7 - k]) : 1'b0;
      e_cs = 4'hF;
      if (enable) begin
        if (cs_sw_own) e_cs[cs_sel] = cs_sw_level;
        else if (m_st != 0) e_cs[cs_sel] = 1'b0;
      end
      chk(sclk == (cpol ^ ((m_st == 2) ? m_ph[0] : 1'b0)), "R3 sclk", sclk, cpol ^ ((m_st == 2) ? m_ph[0] : 1'b0));
      chk(mosi == e_mosi, "R4/R5 mosi", mosi, e_mosi);
      chk(cs_n == e_cs, "R1/R2 cs_n", cs_n, e_cs);
      chk(busy == (m_st != 0), "R6 busy", busy, m_st != 0);
      chk(done == m_done, "R7 done", done, m_done);
      chk(tx_pop == e_pop, "R8 tx_pop", tx_pop, e_pop);
      chk(rx_push == e_push, "R9 rx_push", rx_push, e_push);
      if (e_push) chk(rx_data == e_rx, "R9 rx_data", rx_data, e_rx);
      if (done) done_seen++;
      if (rx_push) push_seen++;
      if (tx_pop) pop_seen++;
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask
  task automatic push(input logic [7:0] b);
    mem[wr] = b; wr = wr + 1;
  endtask
  task automatic go(input int len);
    burst_len = len[7:0]; start = 1; tick(1); start = 0;
  endtask
  task automatic wait_done();
    for (int i = 0; i < 3000; i++) begin tick(1); if (done) break; end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    int d0, p0;
    tick(3);
    rst_n = 1; tick(1);
    checking = 1;
    chk(cs_n == 4'hF, "R1 reset cs_n", cs_n, 4'hF);
    chk(sclk == 0, "R3 reset sclk", sclk, 0);
    chk(busy == 0 && done == 0, "R6 reset busy/done", {busy, done}, 0);
    enable = 1; master = 1; tick(1);

    for (int m = 0; m < 8; m++) begin
      cpha = m[0]; cpol = m[1]; lsb_first = m[2]; cs_sel = m[1:0];
      tick(2);
      p0 = push_seen;
      push(8'h35 + 8'(m * 29)); push(8'hC1 ^ 8'(m)); push(8'h0F);
      go(3);
      chk(busy == 1, "R6 busy after start", busy, 1);
      chk(cs_n[cs_sel] == 0, "R1 select low", cs_n, 0);
      wait_done();
      chk(done == 1 && busy == 0, "R7 done with busy low", {done, busy}, 2);
      tick(1);
      chk(push_seen - p0 == 3, "R9 one push per byte", push_seen - p0, 3);
    end

    cpol = 1; cpha = 0; lsb_first = 0; cs_sel = 1; tick(2);
    push(8'hA5); go(2); tick(60);
    chk(sclk == 1, "R8 stall sclk idle", sclk, 1);
    chk(cs_n == 4'b1101, "R8 stall cs held", cs_n, 4'b1101);
    chk(busy == 1, "R8 stall busy", busy, 1);
    push(8'h3C); wait_done();
    chk(done == 1, "R8 resumed and completed", done, 1);

    cs_sw_own = 1; cs_sw_level = 0; cs_sel = 2; cpol = 0; tick(2);
    chk(cs_n == 4'b1011, "R2 software level", cs_n, 4'b1011);
    push(8'h81); push(8'h7E);
    go(1); wait_done();
    chk(cs_n == 4'b1011, "R2 held across bursts", cs_n, 4'b1011);
    go(1);
    chk(busy == 1, "R11 start in done cycle", busy, 1);
    wait_done();
    cs_sw_level = 1; tick(1);
    chk(cs_n == 4'hF, "R2 software release", cs_n, 4'hF);
    cs_sw_own = 0; tick(2);

    go(0);
    chk(done == 1 && busy == 0, "R7 zero length", {done, busy}, 2);
    tick(1);
    chk(sclk == cpol && done == 0, "R7 zero length no clock", {sclk, done}, {cpol, 1'b0});

    master = 0; push(8'h44); p0 = pop_seen; go(1); tick(10);
    chk(busy == 0, "R6 ignored without master", busy, 0);
    chk(pop_seen == p0, "R6 no pop without master", pop_seen - p0, 0);
    master = 1; go(1); wait_done(); tick(2);

    push(8'h12); push(8'h34); go(2); tick(9);
    d0 = done_seen; soft_reset = 1; tick(1);
    chk(busy == 0 && cs_n == 4'hF, "R10 soft reset idle", {busy, cs_n}, 5'h0F);
    soft_reset = 0; tick(40);
    chk(done_seen == d0, "R10 no done after soft reset", done_seen - d0, 0);

    go(1); tick(5);
    d0 = done_seen; enable = 0; tick(1);
    chk(busy == 0 && cs_n == 4'hF, "R10 disable idle", {busy, cs_n}, 5'h0F);
    tick(20);
    chk(done_seen == d0, "R10 no done after disable", done_seen - d0, 0);
    tick(2);
    checking = 0;
    summary();
  end
endmodule